// File: doc/BRIEF.md
# Memory-Type-Aware Write Combining Buffer

This block holds one 64-byte, line-aligned staging buffer between a store port and a system bus write port. Each incoming store carries an address, a size of 1, 2, 4 or 8 bytes, right-justified data and a memory-type code. Stores of the combinable types are merged into the buffer, which keeps a valid bit for every byte. Stores of the other types are written to the bus on their own.

The merge policy depends on the memory type. Write-combining stores can land anywhere in the open line, in any order. Write-through stores only build one contiguous, ascending run inside a single aligned quadword.

When the buffer must close, the store port is stalled while the buffer drains. A buffer closes on a conflicting store, on a completed run, on a full line, or on an explicit flush request. A full line goes out as an 8-beat burst. A partial line goes out as one 8-byte write for each quadword that holds any valid byte, in ascending address order. Each of those writes carries the quadword's byte-enable mask.

Top module: `wc_line_buffer`

## Requirements
- R1: After reset no bus write is pending (`bus_valid` low), the buffer is empty and the store port is ready.
- R2: Stores typed write-combining (type code 1) merge into the open line in any order, and a later store to an already valid byte replaces that byte. A partial line drains as one 8-byte write per quadword that has any valid byte, lowest address first, with `bus_be` bit k set for each valid byte k of that quadword and `bus_burst` low.
- R3: When all 64 bytes of a write-combining line are valid, the line drains by itself as 8 beats with `bus_burst` high and `bus_be` = 8'hFF, in ascending quadword order.
- R4: Stores typed write-through (type code 2) may open a run at any byte offset of a quadword. Each following write-through store must begin at the byte just after the previous one, and a store that writes byte 7 of the quadword closes and drains the run.
- R5: A write-through store that does not start at the next expected byte first drains the open run, and then begins a new run.
- R6: Stores typed uncacheable (code 0) or write-protected (code 3) are never merged. Each one produces its own single bus write with `bus_burst` low.
- R7: A write-back store (code 4) first drains any open buffer, then is issued on its own as a single write. Codes 5 to 7 are treated as uncacheable.
- R8: A combinable store whose address lies outside the open line, or whose type differs from the open buffer's type, first drains the open buffer and is then merged into a new buffer.
- R9: A one-cycle pulse on `flush` drains an open buffer. With an empty buffer the pulse causes no bus write.
- R10: While the buffer drains or an uncombined write is pending, `st_ready` is low. While `bus_valid` is high and `bus_ready` low, the address, enables, data and burst flag hold steady.
- R11: `st_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. Store addresses are naturally aligned. Byte j of `st_data` lands in lane `st_addr[2:0]`+j of the quadword, and bus addresses are quadword-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store byte address, naturally aligned |
| st_size | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| st_type | input | 3 | Memory type: 0 UC, 1 WC, 2 WT, 3 WP, 4 WB |
| st_data | input | 64 | Store data, right-justified |
| flush | input | 1 | Close and drain the open buffer |
| bus_valid | output | 1 | Bus write command valid |
| bus_ready | input | 1 | Bus accepts the command |
| bus_addr | output | ADDR_W | Quadword-aligned write address |
| bus_be | output | 8 | Byte enables for the quadword |
| bus_data | output | 64 | Write data in byte lanes |
| bus_burst | output | 1 | Beat belongs to a full-line burst |

## Verification
The bench targets overlapping write-combining stores. A design that kept the first byte instead of the last would put stale data on the bus. It also sends a write-through run that starts mid-quadword and ends on byte 7. A design that missed the byte-7 close would leave the run open and merge the next quadword into it.

Further cases cover non-contiguous write-through stores, line misses, type changes and a write-back store behind an open buffer. A design that skipped the close-first step would either mix unrelated stores into one write or issue writes out of order.

The bus is throttled throughout, so a design that dropped or changed a beat under back-pressure would show a lost or altered write. Two more cases cover flushes on an empty buffer and a full line filled out of order, which must give an 8-beat burst rather than eight partial writes.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    typedef enum logic [2:0] {
        MT_UC = 3'd0,
        MT_WC = 3'd1,
        MT_WT = 3'd2,
        MT_WP = 3'd3,
        MT_WB = 3'd4
    } mem_type_e;

    typedef enum logic [1:0] {
        S_COMBINE = 2'd0,
        S_DRAIN   = 2'd1,
        S_PASS    = 2'd2
    } wcb_state_e;
endpackage

// File: rtl/wcb_store_lane.sv
// Places a right-justified store into its quadword byte lanes.
module wcb_store_lane (
    input  logic [2:0]  byte_off,
    input  logic [1:0]  size_code,
    input  logic [63:0] raw_data,
    output logic [3:0]  nbytes,
    output logic [7:0]  lane_be,
    output logic [63:0] lane_data,
    output logic        hits_top
);
    logic [15:0] mask_wide;

    always_comb begin
        nbytes    = 4'd1 << size_code;
        mask_wide = ((16'd1 << nbytes) - 16'd1) << byte_off;
        lane_be   = mask_wide[7:0];
        lane_data = raw_data << {byte_off, 3'b000};
        hits_top  = ({1'b0, byte_off} + nbytes) == 4'd8;
    end
endmodule

// File: rtl/wcb_merge_rules.sv
// Decides whether a store may join the open buffer or forces it closed first.
module wcb_merge_rules
    import wcb_pkg::*;
#(
    parameter int OFF_W = 6,
    parameter int TAG_W = 26
) (
    input  logic             buf_open,
    input  mem_type_e        buf_type,
    input  logic [TAG_W-1:0] buf_tag,
    input  logic [OFF_W-1:0] wt_next,
    input  mem_type_e        st_type,
    input  logic [TAG_W-1:0] st_tag,
    input  logic [OFF_W-1:0] st_off,
    output logic             uncomb,
    output logic             close_first
);
    logic mismatch;

    always_comb begin
        uncomb   = !((st_type == MT_WC) || (st_type == MT_WT));
        mismatch = uncomb
                || (st_type != buf_type)
                || (st_tag != buf_tag)
                || ((st_type == MT_WT) && (st_off != wt_next));
        close_first = buf_open && mismatch;
    end
endmodule

// File: rtl/wc_line_buffer.sv
module wc_line_buffer
    import wcb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [2:0]        st_type,
    input  logic [63:0]       st_data,
    input  logic              flush,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [7:0]        bus_be,
    output logic [63:0]       bus_data,
    output logic              bus_burst
);
    localparam int NQW    = LINE_BYTES / 8;
    localparam int QI_W   = $clog2(NQW);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int LINE_W = LINE_BYTES * 8;

    typedef struct packed {
        wcb_state_e            state;
        logic                  open;
        mem_type_e             mtype;
        logic [TAG_W-1:0]      tag;
        logic [OFF_W-1:0]      wt_next;
        logic [LINE_BYTES-1:0] vld;
        logic [LINE_W-1:0]     data;
        logic [QI_W-1:0]       qidx;
        logic [ADDR_W-1:0]     p_addr;
        logic [7:0]            p_be;
        logic [63:0]           p_data;
    } wcb_regs_t;

    wcb_regs_t r_q, r_d;

    mem_type_e        st_type_e;
    logic [TAG_W-1:0] st_tag;
    logic [OFF_W-1:0] st_off;
    logic [QI_W-1:0]  st_qw;
    logic [3:0]       nbytes;
    logic [7:0]       lane_be;
    logic [63:0]      lane_data;
    logic             hits_top;
    logic             uncomb;
    logic             close_first;
    logic [7:0]       cur_be;
    logic             line_full;

    assign st_type_e = mem_type_e'(st_type);
    assign st_tag    = st_addr[ADDR_W-1:OFF_W];
    assign st_off    = st_addr[OFF_W-1:0];
    assign st_qw     = st_addr[OFF_W-1:3];

    wcb_store_lane u_lane (
        .byte_off  (st_addr[2:0]),
        .size_code (st_size),
        .raw_data  (st_data),
        .nbytes    (nbytes),
        .lane_be   (lane_be),
        .lane_data (lane_data),
        .hits_top  (hits_top)
    );

    wcb_merge_rules #(.OFF_W(OFF_W), .TAG_W(TAG_W)) u_rules (
        .buf_open    (r_q.open),
        .buf_type    (r_q.mtype),
        .buf_tag     (r_q.tag),
        .wt_next     (r_q.wt_next),
        .st_type     (st_type_e),
        .st_tag      (st_tag),
        .st_off      (st_off),
        .uncomb      (uncomb),
        .close_first (close_first)
    );

    assign cur_be    = r_q.vld[{r_q.qidx, 3'b000} +: 8];
    assign line_full = &r_q.vld;
    assign st_ready  = (r_q.state == S_COMBINE) && !flush && !close_first;

    always_comb begin
        r_d       = r_q;
        bus_valid = 1'b0;
        bus_addr  = {r_q.tag, r_q.qidx, 3'b000};
        bus_be    = line_full ? 8'hFF : cur_be;
        bus_data  = r_q.data[{r_q.qidx, 6'b000000} +: 64];
        bus_burst = 1'b0;
        case (r_q.state)
            S_COMBINE: begin
                if (flush) begin
                    if (r_q.open) r_d.state = S_DRAIN;
                end else if (st_valid && close_first) begin
                    r_d.state = S_DRAIN;
                end else if (st_valid) begin
                    if (uncomb) begin
                        r_d.state  = S_PASS;
                        r_d.p_addr = {st_addr[ADDR_W-1:3], 3'b000};
                        r_d.p_be   = lane_be;
                        r_d.p_data = lane_data;
                    end else begin
                        r_d.open    = 1'b1;
                        r_d.mtype   = st_type_e;
                        r_d.tag     = st_tag;
                        r_d.wt_next = st_off + OFF_W'(nbytes);
                        for (int i = 0; i < LINE_BYTES; i++) begin
                            if ((i / 8) == int'(st_qw) && lane_be[i % 8]) begin
                                r_d.data[i*8 +: 8] = lane_data[(i % 8)*8 +: 8];
                                r_d.vld[i]         = 1'b1;
                            end
                        end
                        if (st_type_e == MT_WT && hits_top) r_d.state = S_DRAIN;
                        if (st_type_e == MT_WC && (&r_d.vld)) r_d.state = S_DRAIN;
                    end
                end
            end
            S_DRAIN: begin
                bus_valid = line_full || (|cur_be);
                bus_burst = line_full;
                if (!bus_valid || bus_ready) begin
                    if (r_q.qidx == QI_W'(NQW - 1)) begin
                        r_d.qidx  = '0;
                        r_d.vld   = '0;
                        r_d.open  = 1'b0;
                        r_d.state = S_COMBINE;
                    end else begin
                        r_d.qidx = r_q.qidx + 1'b1;
                    end
                end
            end
            S_PASS: begin
                bus_valid = 1'b1;
                bus_addr  = r_q.p_addr;
                bus_be    = r_q.p_be;
                bus_data  = r_q.p_data;
                if (bus_ready) r_d.state = S_COMBINE;
            end
            default: r_d.state = S_COMBINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be)
                                    && $stable(bus_data) && $stable(bus_burst));
    // R10
    stall_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !st_ready);
    // R3
    burst_full_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_burst |-> bus_be == 8'hFF);
    // R6 R7
    pass_after_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state == S_PASS |-> !r_q.open);
    // R9
    flush_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush && r_q.open && r_q.state == S_COMBINE |=> r_q.state == S_DRAIN);
endmodule

// File: tb/wc_line_buffer_tb.sv
`timescale 1ns/1ps
module wc_line_buffer_tb;
    typedef struct packed {
        logic [31:0] addr;
        logic [7:0]  be;
        logic [63:0] data;
        logic        burst;
        logic [7:0]  req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic [2:0]  st_type = '0;
    logic [63:0] st_data = '0;
    logic        flush = 1'b0;
    logic        bus_valid;
    logic        bus_ready = 1'b1;
    logic [31:0] bus_addr;
    logic [7:0]  bus_be;
    logic [63:0] bus_data;
    logic        bus_burst;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    exp_t q[$];

    // reference model state
    logic [7:0]  m_byte [64];
    logic [63:0] m_vld = '0;
    logic        m_open = 1'b0;
    int          m_type = 0;
    logic [25:0] m_tag = '0;
    int          m_next = 0;

    always #2.5 clk = ~clk;

    wc_line_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_type(st_type), .st_data(st_data),
        .flush(flush), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_data(bus_data), .bus_burst(bus_burst)
    );

    function automatic logic [63:0] be_mask64(input logic [7:0] be);
        logic [63:0] m;
        for (int k = 0; k < 8; k++) m[k*8 +: 8] = {8{be[k]}};
        return m;
    endfunction

    task automatic model_drain(input int req);
        exp_t e;
        if (!m_open) return;
        for (int qw = 0; qw < 8; qw++) begin
            e.addr  = {m_tag, qw[2:0], 3'b000};
            e.burst = &m_vld;
            e.be    = e.burst ? 8'hFF : m_vld[qw*8 +: 8];
            e.req   = 8'(req);
            for (int k = 0; k < 8; k++) e.data[k*8 +: 8] = m_byte[qw*8+k];
            if (e.be != 8'h00) q.push_back(e);
        end
        m_vld  = '0;
        m_open = 1'b0;
    endtask

    // Model first, then drive the store until accepted.
    task automatic send(input logic [31:0] a, input int sz, input int ty,
                        input logic [63:0] d, input int req);
        int n;
        int off;
        logic [7:0] be8;
        logic [63:0] lane;
        logic uc;
        exp_t e;
        n    = 1 << sz;
        off  = int'(a[5:0]);
        be8  = 8'(((16'd1 << n) - 16'd1) << a[2:0]);
        lane = d << (8 * a[2:0]);
        uc   = !(ty == 1 || ty == 2);
        if (m_open && (uc || ty != m_type || a[31:6] != m_tag || (ty == 2 && off != m_next)))
            model_drain(req);
        if (uc) begin
            e.addr = {a[31:3], 3'b000}; e.be = be8; e.data = lane; e.burst = 1'b0;
            e.req = 8'(req);
            q.push_back(e);
        end else begin
            m_open = 1'b1; m_type = ty; m_tag = a[31:6]; m_next = (off + n) % 64;
            for (int k = 0; k < 8; k++)
                if (be8[k]) begin
                    m_byte[{a[5:3], 3'b000} + k] = lane[k*8 +: 8];
                    m_vld[{a[5:3], 3'b000} + k]  = 1'b1;
                end
            if (ty == 2 && (int'(a[2:0]) + n) == 8) model_drain(req);
            else if (ty == 1 && (&m_vld)) model_drain(req);
        end
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_size = 2'(sz); st_type = 3'(ty); st_data = d;
        forever begin
            #1;
            if (st_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_flush(input int req);
        model_drain(req);
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic settle();
        int t = 0;
        while (q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
    endtask

    // Monitor: throttles bus_ready, then samples away from the rising edge.
    always @(negedge clk) begin
        exp_t e;
        cyc++;
        bus_ready = (cyc % 5) != 3;
        #1;
        if (rst_n && bus_valid) begin
            checks++;
            if (st_ready) begin
                errors++;
                $display("FAIL R10: st_ready=%0b expected 0 while bus busy", st_ready);
            end
        end
        if (rst_n && bus_valid && bus_ready) begin
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL R9: unexpected bus write addr=%h be=%h, expected none",
                         bus_addr, bus_be);
            end else begin
                e = q.pop_front();
                if (bus_addr != e.addr || bus_be != e.be || bus_burst != e.burst ||
                    ((bus_data ^ e.data) & be_mask64(e.be)) != 64'd0) begin
                    errors++;
                    $display("FAIL R%0d: got addr=%h be=%h data=%h burst=%0b, expected addr=%h be=%h data=%h burst=%0b",
                             e.req, bus_addr, bus_be, bus_data, bus_burst,
                             e.addr, e.be, e.data, e.burst);
                end
            end
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: run hung, got cycle %0d expected under 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_byte[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        checks++;
        if (bus_valid !== 1'b0 || st_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1: bus_valid=%0b st_ready=%0b expected 0 and 1", bus_valid, st_ready);
        end

        // R2 R11: out-of-order WC merges with overwrite, partial drain
        send(32'h1010, 3, 1, 64'h8877665544332211, 2);
        send(32'h1003, 0, 1, 64'hAA, 2);
        send(32'h1000, 1, 1, 64'hBBCC, 2);
        send(32'h1014, 2, 1, 64'hDEADBEEF, 2);
        send(32'h1001, 0, 1, 64'h5A, 2);
        send(32'h1038, 3, 1, 64'h0123456789ABCDEF, 2);
        do_flush(2);
        settle();

        // R3: full line filled out of order gives an 8-beat burst
        for (int i = 0; i < 8; i++) begin
            int qw;
            qw = (i * 3) % 8;
            send(32'h2000 + 32'(qw * 8), 3, 1, {8{8'(qw + 1)}}, 3);
        end
        settle();

        // R4: WT run opened mid-quadword, closed by byte 7
        send(32'h3002, 0, 2, 64'h11, 4);
        send(32'h3003, 0, 2, 64'h22, 4);
        send(32'h3004, 2, 2, 64'h66554433, 4);
        settle();

        // R5: non-contiguous WT store closes the run first
        send(32'h3100, 1, 2, 64'hA1A0, 5);
        send(32'h3104, 1, 2, 64'hB5B4, 5);
        do_flush(5);
        settle();

        // R6: UC and WP stores are never combined
        send(32'h4000, 0, 0, 64'h01, 6);
        send(32'h4001, 0, 0, 64'h02, 6);
        send(32'h4008, 2, 3, 64'hCAFEF00D, 6);
        settle();

        // R7: WB behind an open WC buffer
        send(32'h4800, 3, 1, 64'h1122334455667788, 7);
        send(32'h4840, 2, 4, 64'h77777777, 7);
        settle();

        // R8: line miss and type change both close first
        send(32'h5000, 2, 1, 64'h10203040, 8);
        send(32'h5040, 2, 1, 64'h50607080, 8);
        send(32'h5048, 0, 2, 64'h99, 8);
        do_flush(8);
        settle();

        // R9: flush with an empty buffer produces no bus write
        do_flush(9);
        do_flush(9);
        settle();

        // R2 R11: mixed sizes over several lines
        for (int i = 0; i < 12; i++) begin
            int sz;
            logic [31:0] a;
            sz = i % 4;
            a  = 32'h6000 + 32'((i / 6) * 64) + 32'(((i * 13) % 8) * 8)
                 + 32'(((i * 5) % (8 >> sz)) << sz);
            send(a, sz, 1, 64'hF0E1D2C3B4A59687 + 64'(i), 11);
        end
        do_flush(11);
        settle();

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d expected writes never issued, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule